// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This unit takes two IEEE-754 operands and returns the lesser or the greater of them. The operation is chosen per request by `op_max`. The format is chosen per request by `dbl_sel`: binary32 uses the low 32 bits of each operand bus, and binary64 uses the full 64 bits. The answer is registered, so it appears one clock after the request. Alongside it comes an invalid-operation bit. A status register outside the block can OR that bit into its own sticky flag.

The NaN rules follow one policy. If only one input is a NaN, quiet or signaling, the numeric input is the result. If both inputs are NaNs, the result is a fixed default NaN made of all ones in the selected format. The invalid bit reports a signaling NaN on either input, even when a number is returned. Ordinary values are ordered by sign first and then by magnitude, with the order reversed for negative values. Negative zero ranks below positive zero, and infinities are treated as ordinary extreme values.

Top module: `fpmm_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was sampled high. The result and the invalid bit of that request appear in the same cycle as `out_valid`.
- R2: While `in_valid` is low, `result` and `invalid` keep their last values and `out_valid` is low, whatever the operand and control inputs do.
- R3: An active-low reset on `rst_n` clears `out_valid`, `result` and `invalid` to zero at once.
- R4: The control input `op_max` selects the operation: 0 returns the lesser operand and 1 returns the greater.
  - Operands of opposite sign are ordered by their sign bit.
  - Positive operands of equal sign are ordered by their exponent-and-mantissa magnitude.
  - For negative operands that magnitude order is reversed.
- R5: Negative zero (sign bit set, all other bits zero) ranks below positive zero. The minimum of the two zeros is therefore negative zero and the maximum is positive zero, in either operand order.
- R6: Infinities (exponent all ones, mantissa zero) are ordered like other numbers and never set `invalid`.
- R7: When exactly one operand is a NaN, quiet or signaling, the result is the other operand, for both minimum and maximum. A NaN has the exponent all ones and a nonzero mantissa.
- R8: When both operands are NaNs, the result is all ones in the selected format, in either order: 0x00000000FFFFFFFF for binary32 and 0xFFFFFFFFFFFFFFFF for binary64.
- R9: `invalid` is 1 exactly when at least one operand is a signaling NaN. The quiet bit is the mantissa MSB: bit 22 for binary32 and bit 51 for binary64. A signaling NaN has that bit clear, and a quiet NaN has it set. Quiet NaNs alone leave `invalid` at 0.
- R10: The control input `dbl_sel` selects the format: 0 for binary32, 1 for binary64.
  - With `dbl_sel` = 0, only bits 31:0 of each operand are used, and the upper operand bits have no effect.
  - With `dbl_sel` = 0, bits 63:32 of `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; operands are sampled on the rising edge |
| op_max | input | 1 | 0 = minimum, 1 = maximum |
| dbl_sel | input | 1 | 0 = binary32 in bits 31:0, 1 = binary64 |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| out_valid | output | 1 | Result of the previous request is present |
| result | output | 64 | Selected value, or the default NaN |
| invalid | output | 1 | Signaling-NaN indication for the request |

## Verification
The bound checker watches these rules on every request:
- the one-cycle handshake and the hold of the outputs while idle;
- the invalid bit against an independent signaling-NaN test of the inputs;
- pass-through of the numeric operand when only one input is a NaN;
- the default NaN when both inputs are NaNs;
- the cleared upper half in binary32 mode;
- that a non-NaN result is always one of the two inputs.

The checker cannot tell which of the two inputs should win. The ordering rules therefore rest on the bench's table of vectors:
- sign, magnitude and the reversal for negative values;
- the signed-zero tie;
- infinities;
- binary32 operands carrying unrelated data in their upper half.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

   typedef enum logic {
      FPMM_MIN = 1'b0,
      FPMM_MAX = 1'b1
   } fpmm_op_e;

   // per-operand classification produced by fpmm_classify
   typedef struct packed {
      logic nan;
      logic snan;
      logic sign;
   } fpmm_cls_t;

   localparam int FPMM_NUM_FMT = 2;   // lane 0 = binary32, lane 1 = binary64

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
   import fpmm_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] val,
   output fpmm_cls_t    cls,
   output logic [W-2:0] mag
);
   logic exp_full;
   logic man_any;
   logic quiet_bit;

   assign exp_full  = &val[W-2 -: EXP_W];
   assign man_any   = |val[MAN_W-1:0];
   assign quiet_bit = val[MAN_W-1];

   always_comb begin
      cls.nan  = exp_full & man_any;
      cls.snan = exp_full & man_any & ~quiet_bit;
      cls.sign = val[W-1];
   end

   assign mag = val[W-2:0];
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
   parameter int W = 32
) (
   input  logic         sign_a,
   input  logic         sign_b,
   input  logic [W-2:0] mag_a,
   input  logic [W-2:0] mag_b,
   output logic         a_below
);
   logic mag_lt;
   logic mag_gt;

   assign mag_lt = mag_a < mag_b;
   assign mag_gt = mag_a > mag_b;

   always_comb begin
      if (sign_a != sign_b)
         a_below = sign_a;                 // negative side ranks lower, covers -0 < +0
      else if (sign_a)
         a_below = mag_gt;                 // both negative: larger magnitude is smaller
      else
         a_below = mag_lt;
   end
endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick
   import fpmm_pkg::*;
#(
   parameter int W = 32
) (
   input  fpmm_op_e     op,
   input  logic         nan_a,
   input  logic         nan_b,
   input  logic         snan_a,
   input  logic         snan_b,
   input  logic         a_below,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output logic         inv
);
   logic take_a;

   assign take_a = (op == FPMM_MIN) ? a_below : ~a_below;

   always_comb begin
      unique case ({nan_a, nan_b})
         2'b11:   res = '1;
         2'b10:   res = b;
         2'b01:   res = a;
         default: res = take_a ? a : b;
      endcase
   end

   assign inv = snan_a | snan_b;
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
   import fpmm_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              op_max,
   input  logic              dbl_sel,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              invalid
);
   localparam int SP_W = 1 + SP_EXP + SP_MAN;
   localparam int DP_W = 1 + DP_EXP + DP_MAN;

   if (DP_W > DATA_W) begin : g_bad_width
      $error("fpmm_unit: binary64 lane wider than DATA_W");
   end
   if (SP_W >= DP_W) begin : g_bad_order
      $error("fpmm_unit: single lane must be narrower than double lane");
   end
   if (SP_MAN < 2 || DP_MAN < 2 || SP_EXP < 2 || DP_EXP < 2) begin : g_bad_field
      $error("fpmm_unit: exponent and mantissa need at least two bits");
   end

   fpmm_op_e          op_sel;
   logic [DATA_W-1:0] lane_res [FPMM_NUM_FMT];
   logic              lane_inv [FPMM_NUM_FMT];
   logic [DATA_W-1:0] nxt_res;
   logic              nxt_inv;

   assign op_sel = op_max ? FPMM_MAX : FPMM_MIN;

   for (genvar g = 0; g < FPMM_NUM_FMT; g++) begin : g_lane
      localparam int EW = (g == 0) ? SP_EXP : DP_EXP;
      localparam int MW = (g == 0) ? SP_MAN : DP_MAN;
      localparam int LW = 1 + EW + MW;

      fpmm_cls_t     cls_a;
      fpmm_cls_t     cls_b;
      logic [LW-2:0] mag_a;
      logic [LW-2:0] mag_b;
      logic          a_below;
      logic [LW-1:0] lres;
      logic          linv;

      fpmm_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls_a (
         .val (opa[LW-1:0]),
         .cls (cls_a),
         .mag (mag_a)
      );

      fpmm_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls_b (
         .val (opb[LW-1:0]),
         .cls (cls_b),
         .mag (mag_b)
      );

      fpmm_order #(.W(LW)) u_order (
         .sign_a  (cls_a.sign),
         .sign_b  (cls_b.sign),
         .mag_a   (mag_a),
         .mag_b   (mag_b),
         .a_below (a_below)
      );

      fpmm_pick #(.W(LW)) u_pick (
         .op      (op_sel),
         .nan_a   (cls_a.nan),
         .nan_b   (cls_b.nan),
         .snan_a  (cls_a.snan),
         .snan_b  (cls_b.snan),
         .a_below (a_below),
         .a       (opa[LW-1:0]),
         .b       (opb[LW-1:0]),
         .res     (lres),
         .inv     (linv)
      );

      assign lane_res[g] = DATA_W'(lres);
      assign lane_inv[g] = linv;
   end

   assign nxt_res = dbl_sel ? lane_res[1] : lane_res[0];
   assign nxt_inv = dbl_sel ? lane_inv[1] : lane_inv[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         invalid   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result  <= nxt_res;
            invalid <= nxt_inv;
         end
      end
   end
endmodule

// File: rtl/fpmm_unit_chk.sv
module fpmm_unit_chk #(
   parameter int DATA_W = 64,
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              dbl_sel,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              invalid
);
   localparam int SW = 1 + SP_EXP + SP_MAN;
   localparam int DW = 1 + DP_EXP + DP_MAN;

   function automatic logic f_nan(input logic [DATA_W-1:0] v, input logic d);
      if (d) return (v[DW-2 -: DP_EXP] == {DP_EXP{1'b1}}) && (v[DP_MAN-1:0] != '0);
      else   return (v[SW-2 -: SP_EXP] == {SP_EXP{1'b1}}) && (v[SP_MAN-1:0] != '0);
   endfunction

   function automatic logic f_snan(input logic [DATA_W-1:0] v, input logic d);
      return f_nan(v, d) && !(d ? v[DP_MAN-1] : v[SP_MAN-1]);
   endfunction

   function automatic logic [DATA_W-1:0] f_trim(input logic [DATA_W-1:0] v, input logic d);
      return d ? v : DATA_W'(v[SW-1:0]);
   endfunction

   logic              a_nan, b_nan, any_snan;
   logic [DATA_W-1:0] a_t, b_t, dflt;

   assign a_nan    = f_nan(opa, dbl_sel);
   assign b_nan    = f_nan(opb, dbl_sel);
   assign any_snan = f_snan(opa, dbl_sel) || f_snan(opb, dbl_sel);
   assign a_t      = f_trim(opa, dbl_sel);
   assign b_t      = f_trim(opb, dbl_sel);
   assign dflt     = dbl_sel ? {DATA_W{1'b1}} : DATA_W'({SW{1'b1}});

   p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(invalid)));

   p_single_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && a_nan && !b_nan) |=> (result == $past(b_t)));

   p_single_nan_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !a_nan && b_nan) |=> (result == $past(a_t)));

   p_dual_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && a_nan && b_nan) |=> (result == $past(dflt)));

   p_snan_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (invalid == $past(any_snan)));

   p_upper_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dbl_sel) |=> (result[DATA_W-1:SW] == '0));

   p_is_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !a_nan && !b_nan) |=> (result == $past(a_t) || result == $past(b_t)));
endmodule

bind fpmm_unit fpmm_unit_chk #(
   .DATA_W (DATA_W),
   .SP_EXP (SP_EXP),
   .SP_MAN (SP_MAN),
   .DP_EXP (DP_EXP),
   .DP_MAN (DP_MAN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .dbl_sel   (dbl_sel),
   .opa       (opa),
   .opb       (opb),
   .out_valid (out_valid),
   .result    (result),
   .invalid   (invalid)
);

// File: tb/fpmm_unit_tb_top.sv
module fpmm_unit_tb_top;

   typedef struct packed {
      logic        mx;
      logic        d;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] r;
      logic        inv;
      logic [3:0]  req;
   } vec_t;

   localparam logic [63:0] D_ONE = 64'h3ff0000000000000;
   localparam logic [63:0] D_NEG = 64'hbd731f7500000000;
   localparam logic [63:0] D_QN  = 64'h7ff8000000000000;
   localparam logic [63:0] D_SN  = 64'h7ff7000000000000;
   localparam int NV = 30;

   localparam vec_t VT [NV] = '{
      '{1'b0, 1'b0, 64'h3f800000, 64'hab98fba8, 64'hab98fba8, 1'b0, 4'd4},  // R4
      '{1'b1, 1'b0, 64'h3f800000, 64'hab98fba8, 64'h3f800000, 1'b0, 4'd4},  // R4
      '{1'b0, 1'b0, 64'hbf800000, 64'hc0000000, 64'hc0000000, 1'b0, 4'd4},  // R4 negatives
      '{1'b1, 1'b0, 64'hbf800000, 64'hc0000000, 64'hbf800000, 1'b0, 4'd4},  // R4
      '{1'b0, 1'b0, 64'h40000000, 64'h3f800000, 64'h3f800000, 1'b0, 4'd4},  // R4
      '{1'b1, 1'b0, 64'h3f800000, 64'h40000000, 64'h40000000, 1'b0, 4'd4},  // R4
      '{1'b0, 1'b0, 64'h00000000, 64'h80000000, 64'h80000000, 1'b0, 4'd5},  // R5
      '{1'b0, 1'b0, 64'h80000000, 64'h00000000, 64'h80000000, 1'b0, 4'd5},  // R5
      '{1'b1, 1'b0, 64'h80000000, 64'h00000000, 64'h00000000, 1'b0, 4'd5},  // R5
      '{1'b1, 1'b0, 64'h00000000, 64'h80000000, 64'h00000000, 1'b0, 4'd5},  // R5
      '{1'b0, 1'b0, 64'h7f800000, 64'h3f800000, 64'h3f800000, 1'b0, 4'd6},  // R6
      '{1'b1, 1'b0, 64'h7f800000, 64'h3f800000, 64'h7f800000, 1'b0, 4'd6},  // R6
      '{1'b0, 1'b0, 64'hff800000, 64'hab98fba8, 64'hff800000, 1'b0, 4'd6},  // R6
      '{1'b0, 1'b0, 64'h3f800000, 64'h7fb00000, 64'h3f800000, 1'b1, 4'd7},  // R7
      '{1'b1, 1'b0, 64'h7fb00000, 64'h3f800000, 64'h3f800000, 1'b1, 4'd7},  // R7
      '{1'b1, 1'b0, 64'h7fc00000, 64'h3f800000, 64'h3f800000, 1'b0, 4'd7},  // R7
      '{1'b0, 1'b0, 64'h3f800000, 64'h7fc00000, 64'h3f800000, 1'b0, 4'd7},  // R7
      '{1'b0, 1'b0, 64'h7fb00000, 64'h7fc00000, 64'hffffffff, 1'b1, 4'd8},  // R8
      '{1'b1, 1'b0, 64'h7fc00000, 64'h7fb00000, 64'hffffffff, 1'b1, 4'd8},  // R8
      '{1'b0, 1'b0, 64'h7fc00000, 64'h7fc00000, 64'hffffffff, 1'b0, 4'd8},  // R8
      '{1'b0, 1'b0, 64'hffc00000, 64'h3f800000, 64'h3f800000, 1'b0, 4'd9},  // R9 quiet
      '{1'b1, 1'b0, 64'h3f800000, 64'hffb00000, 64'h3f800000, 1'b1, 4'd9},  // R9 signaling
      '{1'b0, 1'b1, D_ONE, D_NEG, D_NEG, 1'b0, 4'd10},                      // R10
      '{1'b1, 1'b1, D_ONE, D_NEG, D_ONE, 1'b0, 4'd10},                      // R10
      '{1'b0, 1'b1, D_ONE, D_SN, D_ONE, 1'b1, 4'd9},                        // R9
      '{1'b1, 1'b1, D_QN, D_ONE, D_ONE, 1'b0, 4'd7},                        // R7
      '{1'b0, 1'b1, D_SN, D_QN, 64'hffffffffffffffff, 1'b1, 4'd8},          // R8
      '{1'b0, 1'b0, 64'hdeadbeef3f800000, 64'h12345678ab98fba8,
        64'h00000000ab98fba8, 1'b0, 4'd10},                                 // R10
      '{1'b1, 1'b0, D_QN, 64'h3f800000, 64'h3f800000, 1'b0, 4'd10},         // R10
      '{1'b1, 1'b1, 64'hfff0000000000000, D_NEG, D_NEG, 1'b0, 4'd6}         // R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        op_max = 1'b0;
   logic        dbl_sel = 1'b0;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic        out_valid;
   logic [63:0] result;
   logic        invalid;
   int          total = 0;
   int          bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   fpmm_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_max    (op_max),
      .dbl_sel   (dbl_sel),
      .opa       (opa),
      .opb       (opb),
      .out_valid (out_valid),
      .result    (result),
      .invalid   (invalid)
   );

   task automatic check(input string tag, input logic ok,
                        input logic [65:0] act, input logic [65:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_vec(input int k);
      check($sformatf("R%0d vector %0d", VT[k].req, k),
            out_valid === 1'b1 && result === VT[k].r && invalid === VT[k].inv,
            {out_valid, invalid, result}, {1'b1, VT[k].inv, VT[k].r});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R3: state while reset is held
      @(negedge clk);
      check("R3 reset state", out_valid === 1'b0 && result === '0 && invalid === 1'b0,
            {out_valid, invalid, result}, '0);
      rst_n = 1'b1;

      // table walk, one request per cycle, back to back (R1 latency)
      for (int i = 0; i <= NV; i++) begin
         @(negedge clk);
         if (i > 0) check_vec(i - 1);
         if (i < NV) begin
            in_valid = 1'b1;
            op_max   = VT[i].mx;
            dbl_sel  = VT[i].d;
            opa      = VT[i].a;
            opb      = VT[i].b;
         end
      end

      // R2: idle cycles with wild inputs leave outputs alone
      in_valid = 1'b0;
      op_max   = 1'b0;
      dbl_sel  = 1'b0;
      opa      = 64'h7fb00000;
      opb      = 64'h7fc00000;
      for (int j = 0; j < 2; j++) begin
         @(negedge clk);
         check("R2 hold while idle", out_valid === 1'b0 && result === VT[NV-1].r && invalid === 1'b0,
               {out_valid, invalid, result}, {2'b00, VT[NV-1].r});
      end

      // R1: single isolated request, valid pulse of one cycle
      in_valid = 1'b1;
      opa      = 64'h7fb00000;
      opb      = 64'h40000000;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 isolated request", out_valid === 1'b1 && result === 64'h40000000 && invalid === 1'b1,
            {out_valid, invalid, result}, {2'b11, 64'h40000000});
      @(negedge clk);
      check("R1 valid drops", out_valid === 1'b0, {65'd0, out_valid}, '0);

      // R3: asynchronous reset after activity
      rst_n = 1'b0;
      #1;
      check("R3 reset clears", out_valid === 1'b0 && result === '0 && invalid === 1'b0,
            {out_valid, invalid, result}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 stays clear after release", out_valid === 1'b0 && result === '0,
            {out_valid, invalid, result}, '0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule